// File: doc/BRIEF.md
# Triple-Channel Converter Serial Control Front End

This block is the digital side of a three-channel, 8-bit voltage converter. A host writes it over a three-wire serial link made of an active-low select, a serial clock and a data line. Every write is a 16-bit frame. The first byte is a control byte: one load flag and one power-down flag per channel, a general-purpose logic output bit, and one spare bit. The second byte is the code that the load flags copy into the channel registers. The block holds the three channel codes, the per-channel power-down state and the logic output. It presents them to the analog section as a code bus, per-channel drive enables and power-down flags.

The serial pins are sampled in a faster system clock through two-flop synchronizers. Edges are detected in that clock domain. Nothing is applied while the frame is being shifted. When select returns high, the whole frame takes effect in one step, and only if at least sixteen bits arrived. Channels A and B float their outputs when powered down. Channel C drives zero when powered down. Stored codes are never lost by a power-down. A dedicated active-low clear pin, and the synchronous system reset, both restore the power-on state.

Top module: `tdac_ctrl`

## Requirements
- R1: After the system reset, or while the synchronized clear pin `clr_n` is low, channels A and B hold code FF hex and channel C holds 00 hex. All drive enables are 1, all power-down flags are 0 and `lout` is 0.
- R2: A bit is taken from `sdi` on each rising edge of `sclk` while `cs_n` is low, most significant bit first. Frame bits, counting from bit 15 (sent first) down to bit 0, are: 15 spare, 14 logic output, 13/12/11 power-down C/B/A, 10/9/8 load C/B/A, 7..0 code.
- R3: In a committed frame, every channel whose load bit is 1 takes the code byte, so several channels can receive the same value. A channel whose load bit is 0 keeps its code.
- R4: Outputs change only when a frame commits, which happens on the rising edge of `cs_n`. A full frame shifted in with `cs_n` still low leaves every output unchanged.
- R5: A frame with fewer than 16 bits shifted since `cs_n` fell is discarded on the rising edge of `cs_n`.
- R6: When more than 16 bits are shifted, the last 16 bits form the frame.
- R7: A frame may arrive as two 8-bit bursts with an idle pause of `sclk` between them, as long as `cs_n` stays low.
- R8: A channel with power-down bit 1 raises its flag in `ch_sd`. Channels A and B then drop their drive enable and keep their code on the bus. Channel C keeps its drive enable high and shows code 00.
- R9: A power-down bit of 0 in a committed frame reactivates that channel. The channel then shows its stored code, including any code loaded while it was powered down.
- R10: `lout` follows frame bit 14 on each commit and does not depend on the power-down state. Bit 15 has no effect.
- R11: A clear pulse on `clr_n` in the middle of a frame resets the bit count. The partial frame cannot then complete into a commit.
- R12: `sclk` edges while `cs_n` is high shift nothing and do not count toward the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| clr_n | input | 1 | Active-low clear pin (asynchronous to `clk`, synchronized inside) |
| sclk | input | 1 | Serial clock |
| cs_n | input | 1 | Active-low serial select |
| sdi | input | 1 | Serial data in |
| ch_code | output | 24 | Channel codes, A at [7:0], B at [15:8], C at [23:16] |
| ch_oe | output | 3 | Per-channel drive enable (bit 0 = A) |
| ch_sd | output | 3 | Per-channel power-down flag (bit 0 = A) |
| lout | output | 1 | General-purpose logic output |

## Verification
The bench targets bit-count corner cases: a 12-bit frame, a 20-bit frame, a frame split into two bursts with a pause, and clock pulses while select is high. A design that commits without counting bits would apply the short frame. A design that counts from the first bit, or that counts while select is high, would accept or misalign frames. The bench also checks the asymmetric power-down behaviour. If channel C floated instead of driving zero, or if a power-down cleared the stored code, the bus would show the wrong value after wake-up. A clear pulse in the middle of a frame checks that the half-received bits are discarded instead of completing into a commit.

// File: rtl/tdac_pkg.sv
package tdac_pkg;
  // Position of the load flag of channel i in a frame of 2*dw bits
  function automatic int ld_pos(input int dw, input int i);
    return dw + i;
  endfunction

  // Position of the power-down flag of channel i
  function automatic int sd_pos(input int dw, input int nch, input int i);
    return dw + nch + i;
  endfunction

  // Position of the logic-output bit
  function automatic int lout_pos(input int dw, input int nch);
    return dw + 2 * nch;
  endfunction
endpackage

// File: rtl/tdac_edge_sync.sv
module tdac_edge_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] pipe;
    logic              prev;
    always_ff @(posedge clk) begin
      if (rst) begin
        pipe <= {STAGES{RST_VAL[b]}};
        prev <= RST_VAL[b];
      end else begin
        pipe <= {pipe[STAGES-2:0], async_i[b]};
        prev <= pipe[STAGES-1];
      end
    end
    assign sync_o[b] = pipe[STAGES-1];
    assign rise_o[b] = pipe[STAGES-1] & ~prev;
    assign fall_o[b] = ~pipe[STAGES-1] & prev;
  end
endmodule

// File: rtl/tdac_shift.sv
module tdac_shift #(
  parameter int FW = 16,
  localparam int CW = $clog2(FW + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel_low,
  input  logic          sck_rise,
  input  logic          sel_rise,
  input  logic          din,
  output logic [FW-1:0] frame_o,
  output logic [CW-1:0] cnt_o,
  output logic          commit_o
);
  logic [FW-1:0] sr;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr  <= '0;
      cnt <= '0;
    end else if (!sel_low) begin
      cnt <= '0;
    end else if (sck_rise) begin
      sr <= {sr[FW-2:0], din};
      if (cnt != CW'(FW)) cnt <= cnt + 1'b1;
    end
  end

  assign frame_o  = sr;
  assign cnt_o    = cnt;
  assign commit_o = sel_rise && (cnt == CW'(FW));
endmodule

// File: rtl/tdac_chan.sv
module tdac_chan #(
  parameter int DW = 8,
  parameter logic [DW-1:0] RST_CODE = '1,
  parameter bit ZERO_ON_SD = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          commit,
  input  logic          ld,
  input  logic          sd_req,
  input  logic [DW-1:0] data,
  output logic [DW-1:0] code_o,
  output logic          oe_o,
  output logic          sd_o
);
  logic [DW-1:0] held;
  logic [DW-1:0] held_nx;

  assign held_nx = ld ? data : held;

  always_ff @(posedge clk) begin
    if (rst) begin
      held   <= RST_CODE;
      code_o <= RST_CODE;
      oe_o   <= 1'b1;
      sd_o   <= 1'b0;
    end else if (commit) begin
      held <= held_nx;
      sd_o <= sd_req;
      if (ZERO_ON_SD) begin
        code_o <= sd_req ? '0 : held_nx;
        oe_o   <= 1'b1;
      end else begin
        code_o <= held_nx;
        oe_o   <= ~sd_req;
      end
    end
  end
endmodule

// File: rtl/tdac_ctrl.sv
module tdac_ctrl #(
  parameter int NCH = 3,
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [NCH-1:0] RST_HI_MASK = 3'b011,
  parameter logic [NCH-1:0] HIZ_MASK = 3'b011
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              sdi,
  output logic [NCH*DW-1:0] ch_code,
  output logic [NCH-1:0]    ch_oe,
  output logic [NCH-1:0]    ch_sd,
  output logic              lout
);
  import tdac_pkg::*;

  localparam int FW = 2 * DW;
  localparam int CW = $clog2(FW + 1);
  localparam int LOUT_BIT = lout_pos(DW, NCH);

  // synchronizer lanes: 0 sclk, 1 cs_n, 2 sdi, 3 clr_n
  logic [3:0] pin_s, pin_rise, sync_fall_unused;
  logic       rst_int;
  logic [FW-1:0] frame;
  logic [CW-1:0] cnt;
  logic          commit;
  logic          unused_ctl;

  tdac_edge_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1010)) u_sync (
    .clk(clk), .rst(rst),
    .async_i({clr_n, sdi, cs_n, sclk}),
    .sync_o(pin_s), .rise_o(pin_rise), .fall_o(sync_fall_unused)
  );

  assign rst_int = rst | ~pin_s[3];

  tdac_shift #(.FW(FW)) u_shift (
    .clk(clk), .rst(rst_int),
    .sel_low(~pin_s[1]), .sck_rise(pin_rise[0]), .sel_rise(pin_rise[1]),
    .din(pin_s[2]), .frame_o(frame), .cnt_o(cnt), .commit_o(commit)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    tdac_chan #(
      .DW(DW),
      .RST_CODE({DW{RST_HI_MASK[i]}}),
      .ZERO_ON_SD(!HIZ_MASK[i])
    ) u_chan (
      .clk(clk), .rst(rst_int), .commit(commit),
      .ld(frame[ld_pos(DW, i)]),
      .sd_req(frame[sd_pos(DW, NCH, i)]),
      .data(frame[DW-1:0]),
      .code_o(ch_code[i*DW +: DW]),
      .oe_o(ch_oe[i]),
      .sd_o(ch_sd[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst_int)     lout <= 1'b0;
    else if (commit) lout <= frame[LOUT_BIT];
  end

  assign unused_ctl = ^{frame[FW-1:LOUT_BIT+1], sync_fall_unused, pin_rise[3:2]};
endmodule

// File: rtl/tdac_ctrl_chk.sv
module tdac_ctrl_chk #(
  parameter int NCH = 3,
  parameter int DW = 8,
  parameter logic [NCH-1:0] RST_HI_MASK = 3'b011,
  parameter logic [NCH-1:0] HIZ_MASK = 3'b011,
  localparam int FW = 2 * DW,
  localparam int CW = $clog2(FW + 1)
) (
  input logic              clk,
  input logic              rst_int,
  input logic              commit,
  input logic [FW-1:0]     frame,
  input logic [CW-1:0]     cnt,
  input logic [NCH*DW-1:0] ch_code,
  input logic [NCH-1:0]    ch_oe,
  input logic [NCH-1:0]    ch_sd,
  input logic              lout
);
  logic [NCH*DW-1:0] rst_codes;
  always_comb
    for (int i = 0; i < NCH; i++) rst_codes[i*DW +: DW] = {DW{RST_HI_MASK[i]}};

  p_reset_vals_r1: assert property (@(posedge clk)
    rst_int |=> (ch_code == rst_codes) && (ch_oe == '1) && (ch_sd == '0) && !lout);

  p_hold_no_commit_r4: assert property (@(posedge clk) disable iff (rst_int)
    !commit |=> $stable(ch_code) && $stable(ch_oe) && $stable(ch_sd) && $stable(lout));

  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst_int)
    cnt <= CW'(FW));

  p_lout_r10: assert property (@(posedge clk) disable iff (rst_int)
    commit |=> lout == $past(frame[2*NCH+DW]));

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    p_load_r3: assert property (@(posedge clk) disable iff (rst_int)
      commit && frame[DW+i] && !(frame[DW+NCH+i] && !HIZ_MASK[i])
      |=> ch_code[i*DW +: DW] == $past(frame[DW-1:0]));
    p_active_r9: assert property (@(posedge clk) disable iff (rst_int)
      !ch_sd[i] |-> ch_oe[i]);
    if (HIZ_MASK[i]) begin : g_hiz
      p_sd_float_r8: assert property (@(posedge clk) disable iff (rst_int)
        ch_sd[i] |-> !ch_oe[i]);
    end else begin : g_zero
      p_sd_zero_r8: assert property (@(posedge clk) disable iff (rst_int)
        ch_sd[i] |-> ch_oe[i] && (ch_code[i*DW +: DW] == '0));
    end
  end
endmodule

bind tdac_ctrl tdac_ctrl_chk #(
  .NCH(NCH), .DW(DW), .RST_HI_MASK(RST_HI_MASK), .HIZ_MASK(HIZ_MASK)
) u_chk (
  .clk(clk), .rst_int(rst_int), .commit(commit), .frame(frame), .cnt(cnt),
  .ch_code(ch_code), .ch_oe(ch_oe), .ch_sd(ch_sd), .lout(lout)
);

// File: tb/tdac_ctrl_bench.sv
module tdac_ctrl_bench;
  localparam int H = 6;
  logic clk = 1'b0;
  logic rst = 1'b1, clr_n = 1'b1, sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0;
  logic [23:0] ch_code;
  logic [2:0]  ch_oe, ch_sd;
  logic        lout;
  int checks = 0, fails = 0;
  logic [7:0] m_held [3];
  logic [2:0] m_sd;
  logic       m_lout;

  always #2.5 clk = ~clk;

  tdac_ctrl u_tdac_ctrl (
    .clk(clk), .rst(rst), .clr_n(clr_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .ch_code(ch_code), .ch_oe(ch_oe), .ch_sd(ch_sd), .lout(lout)
  );

  task automatic model_reset();
    m_held[0] = 8'hFF; m_held[1] = 8'hFF; m_held[2] = 8'h00;
    m_sd = 3'b000; m_lout = 1'b0;
  endtask

  // bit 15 spare, 14 lout, 13..11 sd C..A, 10..8 load C..A, 7..0 code
  task automatic model_apply(input logic [15:0] w);
    for (int i = 0; i < 3; i++) begin
      if (w[8+i]) m_held[i] = w[7:0];
      m_sd[i] = w[11+i];
    end
    m_lout = w[14];
  endtask

  function automatic logic [31:0] expect_vec();
    logic [23:0] c;
    logic [2:0]  oe;
    for (int i = 0; i < 3; i++) begin
      c[i*8 +: 8] = (i == 2 && m_sd[i]) ? 8'h00 : m_held[i];
      oe[i]       = (i < 2 && m_sd[i]) ? 1'b0 : 1'b1;
    end
    return {1'b0, m_sd, oe, m_lout, c};
  endfunction

  task automatic check(input string req);
    logic [31:0] act, exp;
    @(negedge clk);
    act = {1'b0, ch_sd, ch_oe, lout, ch_code};
    exp = expect_vec();
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic sel_low();
    @(negedge clk); cs_n = 1'b0; repeat (H) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [31:0] w, input int n);
    for (int k = n - 1; k >= 0; k--) begin
      sdi = w[k]; repeat (H) @(negedge clk);
      sclk = 1'b1; repeat (H) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic sel_high();
    repeat (H) @(negedge clk); cs_n = 1'b1; repeat (10) @(negedge clk);
  endtask

  task automatic send_frame(input logic [15:0] w);
    sel_low(); shift_bits({16'h0, w}, 16); sel_high(); model_apply(w);
  endtask

  task automatic t_reset();
    model_reset(); check("R1 reset state");
  endtask

  task automatic t_load_single();
    sel_low(); shift_bits(32'h015A, 16); repeat (12) @(negedge clk);
    check("R4 no change before select rises");
    sel_high(); model_apply(16'h015A); check("R2 R3 load A");
  endtask

  task automatic t_load_multi();
    send_frame(16'h0633); check("R3 load B and C together");
  endtask

  task automatic t_lout();
    send_frame(16'hC000); check("R10 lout set, spare bit ignored");
  endtask

  task automatic t_shutdown();
    send_frame(16'h7800); check("R8 all channels powered down, R10 lout kept");
    send_frame(16'h7C77); check("R9 load C while powered down");
    send_frame(16'h4000); check("R9 wake restores held codes");
  endtask

  task automatic t_short();
    sel_low(); shift_bits(32'h0FFF, 12); sel_high(); check("R5 short frame ignored");
  endtask

  task automatic t_long();
    sel_low(); shift_bits(32'h000A0281, 20); sel_high();
    model_apply(16'h0281); check("R6 last 16 of 20 bits used");
  endtask

  task automatic t_split();
    sel_low(); shift_bits(32'h02, 8); repeat (40) @(negedge clk);
    shift_bits(32'h9C, 8); sel_high(); model_apply(16'h029C);
    check("R7 two bursts with pause");
  endtask

  task automatic t_sclk_idle();
    sdi = 1'b1;
    for (int k = 0; k < 4; k++) begin
      repeat (H) @(negedge clk); sclk = 1'b1; repeat (H) @(negedge clk); sclk = 1'b0;
    end
    sel_low(); shift_bits(32'h0144, 12); sel_high();
    check("R12 clocks with select high not counted");
  endtask

  task automatic t_clear();
    send_frame(16'h3911); check("R8 A powered down before clear");
    sel_low(); shift_bits(32'h01, 8);
    clr_n = 1'b0; repeat (6) @(negedge clk); clr_n = 1'b1; repeat (4) @(negedge clk);
    model_reset(); check("R1 clear pin restores reset state");
    shift_bits(32'h22, 8); sel_high(); check("R11 partial frame discarded after clear");
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    model_reset();
    repeat (5) @(negedge clk); rst = 1'b0; repeat (6) @(negedge clk);
    t_reset();
    t_load_single();
    t_load_multi();
    t_lout();
    t_shutdown();
    t_short();
    t_long();
    t_split();
    t_sclk_idle();
    t_clear();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule